// File: doc/BRIEF.md
# Delay-Ordered Carry-Save Reduction Tree

This block takes a rectangular array of partial-product rows, such as a radix-4 recoded multiplier produces, and compresses it to two rows whose modular sum equals the sum of all input rows. Row r of the array occupies `pp_flat[r*COLS +: COLS]`, and bit c of every row belongs to weight column c. The compression is a tree of full adders and half adders, arranged level by level. A level runs until no column holds more than two bits. Every carry moves to the next higher column at the following level. The carry out of the top column is dropped, so all arithmetic is modulo 2^COLS.

The wiring inside each level is set at elaboration from a unit-delay estimate. In that estimate an XOR costs 2 units and a NAND costs 1. Inside a column, the bits are ranked by estimated arrival time and taken in groups of three. In each group the two earliest bits feed the adder inputs whose path to the sum is long, and the latest bit feeds the carry-in, whose path is short. Late sum bits from the previous level therefore land on the carry-in pins rather than on the deep paths. A column left with two bits uses a half adder only if it held three or more bits at that level. One output register captures the two rows whenever an input is accepted. The final carry-propagate addition is left to the consumer.

Top module: `csa_reduction_tree`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `out_valid`, `sum_row` and `carry_row` are all zero.
- R2: `out_valid` is high in the cycle after a rising clock edge at which `in_valid` was high, and low after an edge at which `in_valid` was low.
- R3: After an edge that accepts an input, `(sum_row + carry_row) mod 2^COLS` equals the sum over r of `pp_flat[r*COLS +: COLS]`, modulo 2^COLS.
- R4: After an edge with `in_valid` low, `sum_row` and `carry_row` keep their values, whatever `pp_flat` carries.
- R5: Overflow out of the top column is discarded. With every input bit set, the result is `ROWS*(2^COLS-1) mod 2^COLS`.
- R6: A new input can be accepted on every cycle, and each result appears one cycle after its own input with no bubble.
- R7: Rows built by radix-4 recoding of two signed 8-bit operands give their signed product modulo 2^COLS. Each negated row is one's-complemented and sign-extended to COLS bits. Its +1 correction sits at bit 2i of one extra row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The array on `pp_flat` is accepted at this edge |
| pp_flat | input | ROWS*COLS | Partial-product rows, row r at bits `[r*COLS +: COLS]` |
| out_valid | output | 1 | `sum_row`/`carry_row` hold a freshly accepted result |
| sum_row | output | COLS | First compressed row |
| carry_row | output | COLS | Second compressed row |

## Verification
The tree is purely combinational, so each result and its `out_valid` are due exactly one rising edge after the edge that accepted the input. The bench drives inputs on falling edges and reads both rows on the next falling edge, half a period after the register has loaded. Held values and the low `out_valid` after an idle cycle are read at that same falling edge. Reset is checked a short delay after `rst_n` falls, because the clear does not wait for a clock edge.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  localparam int T_NAND     = 1;
  localparam int T_XOR      = 2;
  localparam int MAX_COLS   = 32;
  localparam int MAX_H      = 12;
  localparam int MAX_LEVELS = 12;

  typedef logic [7:0] u8_t;

  // Per-column bit count and per-slot arrival estimate for one tree level.
  typedef struct packed {
    u8_t [MAX_COLS-1:0]            hgt;
    u8_t [MAX_COLS-1:0][MAX_H-1:0] arr;
  } tree_state_t;

  function automatic int max2(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // Full adder: sum = (a^b)^cin ; cout = nand(nand(a,b), nand(a^b,cin))
  function automatic int fa_sum_time(input int ta, input int tb, input int tc);
    return max2(max2(ta, tb) + 2 * T_XOR, tc + T_XOR);
  endfunction

  function automatic int fa_carry_time(input int ta, input int tb, input int tc);
    return max2(max2(ta, tb) + T_XOR + 2 * T_NAND, tc + 2 * T_NAND);
  endfunction

  function automatic int ha_sum_time(input int ta, input int tb);
    return max2(ta, tb) + T_XOR;
  endfunction

  function automatic int ha_carry_time(input int ta, input int tb);
    return max2(ta, tb) + 2 * T_NAND;
  endfunction

  function automatic int fa_count(input int h);
    return (h > 2) ? h / 3 : 0;
  endfunction

  function automatic bit has_ha(input int h);
    return (h > 2) && (h % 3 == 2);
  endfunction

  function automatic int pass_count(input int h);
    if (h <= 2) return h;
    return (h % 3 == 1) ? 1 : 0;
  endfunction

  function automatic int col_height(input tree_state_t s, input int c);
    if (c < 0 || c >= MAX_COLS) return 0;
    return int'(s.hgt[c]);
  endfunction

  // Slot holding the bit of the given arrival rank (stable on ties).
  function automatic int rank_slot(input tree_state_t s, input int c, input int r);
    int h;
    int cnt;
    h = col_height(s, c);
    for (int k = 0; k < MAX_H; k++) begin
      if (k < h) begin
        cnt = 0;
        for (int j = 0; j < MAX_H; j++) begin
          if (j < h && (s.arr[c][j] < s.arr[c][k] ||
                        (s.arr[c][j] == s.arr[c][k] && j < k)))
            cnt++;
        end
        if (cnt == r) return k;
      end
    end
    return 0;
  endfunction

  function automatic int rank_time(input tree_state_t s, input int c, input int r);
    return int'(s.arr[c][rank_slot(s, c, r)]);
  endfunction

  function automatic tree_state_t initial_state(input int cols, input int rows);
    tree_state_t s;
    s = '0;
    for (int c = 0; c < MAX_COLS; c++)
      if (c < cols) s.hgt[c] = u8_t'(rows);
    return s;
  endfunction

  // Output slot order of column c: pass bits, FA sums, HA sum,
  // then carries of column c-1 (FA carries, HA carry).
  function automatic tree_state_t next_state(input tree_state_t s, input int cols);
    tree_state_t n;
    int h, hp, k;
    n = '0;
    for (int c = 0; c < MAX_COLS; c++) begin
      if (c < cols) begin
        h = col_height(s, c);
        k = 0;
        for (int p = 0; p < pass_count(h); p++) begin
          n.arr[c][k] = u8_t'(rank_time(s, c, (h <= 2) ? p : h - 1));
          k++;
        end
        for (int j = 0; j < fa_count(h); j++) begin
          n.arr[c][k] = u8_t'(fa_sum_time(rank_time(s, c, 3*j), rank_time(s, c, 3*j+1),
                                          rank_time(s, c, 3*j+2)));
          k++;
        end
        if (has_ha(h)) begin
          n.arr[c][k] = u8_t'(ha_sum_time(rank_time(s, c, 3*fa_count(h)),
                                          rank_time(s, c, 3*fa_count(h)+1)));
          k++;
        end
        if (c > 0) begin
          hp = col_height(s, c - 1);
          for (int j = 0; j < fa_count(hp); j++) begin
            n.arr[c][k] = u8_t'(fa_carry_time(rank_time(s, c-1, 3*j), rank_time(s, c-1, 3*j+1),
                                              rank_time(s, c-1, 3*j+2)));
            k++;
          end
          if (has_ha(hp)) begin
            n.arr[c][k] = u8_t'(ha_carry_time(rank_time(s, c-1, 3*fa_count(hp)),
                                              rank_time(s, c-1, 3*fa_count(hp)+1)));
            k++;
          end
        end
        n.hgt[c] = u8_t'(k);
      end
    end
    return n;
  endfunction

  function automatic bit is_flat(input tree_state_t s, input int cols);
    for (int c = 0; c < MAX_COLS; c++)
      if (c < cols && s.hgt[c] > 8'd2) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int level_count(input int cols, input int rows);
    tree_state_t s;
    int n;
    s = initial_state(cols, rows);
    n = 0;
    for (int i = 0; i < MAX_LEVELS; i++) begin
      if (!is_flat(s, cols)) begin
        s = next_state(s, cols);
        n++;
      end
    end
    return n;
  endfunction

  function automatic tree_state_t state_at(input int cols, input int rows, input int lvl);
    tree_state_t s;
    s = initial_state(cols, rows);
    for (int i = 0; i < MAX_LEVELS; i++)
      if (i < lvl) s = next_state(s, cols);
    return s;
  endfunction

endpackage

// File: rtl/csa_full_adder.sv
module csa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  // a/b reach sum through two XORs; cin through one.
  logic ab_xor;
  logic ab_nand;
  logic mix_nand;

  assign ab_xor   = a ^ b;
  assign sum      = ab_xor ^ cin;
  assign ab_nand  = ~(a & b);
  assign mix_nand = ~(ab_xor & cin);
  assign cout     = ~(ab_nand & mix_nand);
endmodule

// File: rtl/csa_half_adder.sv
module csa_half_adder (
  input  logic a,
  input  logic b,
  output logic sum,
  output logic cout
);
  assign sum  = a ^ b;
  assign cout = a & b;
endmodule

// File: rtl/csa_tree_level.sv
module csa_tree_level
  import csa_tree_pkg::*;
#(
  parameter int          COLS = 16,
  parameter int          MAXH = 6,
  parameter tree_state_t ST   = '0
) (
  input  logic [COLS*MAXH-1:0] bits_in,
  output logic [COLS*MAXH-1:0] bits_out
);
  localparam int FA_MAX = (MAXH / 3 > 0) ? MAXH / 3 : 1;

  logic [FA_MAX-1:0] fa_sum [COLS];
  logic [FA_MAX-1:0] fa_cry [COLS];
  logic [COLS-1:0]   ha_sum;
  logic [COLS-1:0]   ha_cry;
  logic              unused_top;

  assign unused_top = ^{ha_sum, ha_cry};

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int H      = col_height(ST, c);
    localparam int NFA    = fa_count(H);
    localparam bit HAS_HA = has_ha(H);
    localparam int NP     = pass_count(H);
    localparam int HP     = col_height(ST, c - 1);
    localparam int NFA_P  = fa_count(HP);
    localparam bit HA_P   = has_ha(HP);
    localparam int BASE   = NP + NFA + (HAS_HA ? 1 : 0);

    logic [MAXH-1:0] col_in;
    logic [MAXH-1:0] col_out;
    logic            unused_col;

    assign col_in     = bits_in[c*MAXH +: MAXH];
    assign unused_col = ^{col_in, fa_sum[c], fa_cry[c]};

    // Triples in arrival order: earliest two on a/b, latest on cin.
    for (genvar j = 0; j < FA_MAX; j++) begin : g_fa
      if (j < NFA) begin : g_on
        localparam int SA = rank_slot(ST, c, 3*j);
        localparam int SB = rank_slot(ST, c, 3*j + 1);
        localparam int SC = rank_slot(ST, c, 3*j + 2);
        csa_full_adder u_fa (
          .a   (col_in[SA]),
          .b   (col_in[SB]),
          .cin (col_in[SC]),
          .sum (fa_sum[c][j]),
          .cout(fa_cry[c][j])
        );
      end else begin : g_off
        assign fa_sum[c][j] = 1'b0;
        assign fa_cry[c][j] = 1'b0;
      end
    end

    if (HAS_HA) begin : g_ha
      localparam int HA_A = rank_slot(ST, c, 3*NFA);
      localparam int HA_B = rank_slot(ST, c, 3*NFA + 1);
      csa_half_adder u_ha (
        .a   (col_in[HA_A]),
        .b   (col_in[HA_B]),
        .sum (ha_sum[c]),
        .cout(ha_cry[c])
      );
    end else begin : g_no_ha
      assign ha_sum[c] = 1'b0;
      assign ha_cry[c] = 1'b0;
    end

    for (genvar k = 0; k < MAXH; k++) begin : g_slot
      if (k < NP) begin : g_pass
        localparam int SRC = rank_slot(ST, c, (H <= 2) ? k : H - 1);
        assign col_out[k] = col_in[SRC];
      end else if (k < NP + NFA) begin : g_sum
        assign col_out[k] = fa_sum[c][k - NP];
      end else if (HAS_HA && k == NP + NFA) begin : g_hsum
        assign col_out[k] = ha_sum[c];
      end else if (c > 0 && k < BASE + NFA_P) begin : g_cry
        assign col_out[k] = fa_cry[c - 1][k - BASE];
      end else if (c > 0 && HA_P && k == BASE + NFA_P) begin : g_hcry
        assign col_out[k] = ha_cry[c - 1];
      end else begin : g_empty
        assign col_out[k] = 1'b0;
      end
    end

    assign bits_out[c*MAXH +: MAXH] = col_out;
  end
endmodule

// File: rtl/csa_reduction_tree.sv
module csa_reduction_tree
  import csa_tree_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ROWS*COLS-1:0] pp_flat,
  output logic                 out_valid,
  output logic [COLS-1:0]      sum_row,
  output logic [COLS-1:0]      carry_row
);
  localparam int          MAXH = ROWS;
  localparam int          NLV  = level_count(COLS, ROWS);
  localparam tree_state_t FIN  = state_at(COLS, ROWS, NLV);

  logic [COLS*MAXH-1:0] stage [NLV+1];
  logic [COLS-1:0]      flat_sum;
  logic [COLS-1:0]      flat_cry;
  logic [COLS-1:0]      ref_total;
  logic                 unused_final;

  // Column-major re-arrangement: column c, slot r <- row r, bit c.
  for (genvar c = 0; c < COLS; c++) begin : g_in_col
    for (genvar r = 0; r < ROWS; r++) begin : g_in_row
      assign stage[0][c*MAXH + r] = pp_flat[r*COLS + c];
    end
  end

  for (genvar l = 0; l < NLV; l++) begin : g_level
    localparam tree_state_t ST_L = state_at(COLS, ROWS, l);
    csa_tree_level #(
      .COLS(COLS),
      .MAXH(MAXH),
      .ST  (ST_L)
    ) u_level (
      .bits_in (stage[l]),
      .bits_out(stage[l+1])
    );
  end

  for (genvar c = 0; c < COLS; c++) begin : g_out_col
    if (FIN.hgt[c] >= 8'd1) begin : g_s
      assign flat_sum[c] = stage[NLV][c*MAXH];
    end else begin : g_s0
      assign flat_sum[c] = 1'b0;
    end
    if (FIN.hgt[c] >= 8'd2) begin : g_c
      assign flat_cry[c] = stage[NLV][c*MAXH + 1];
    end else begin : g_c0
      assign flat_cry[c] = 1'b0;
    end
  end

  assign unused_final = ^stage[NLV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_row   <= '0;
      carry_row <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_row   <= flat_sum;
        carry_row <= flat_cry;
      end
    end
  end

  // Plain row-by-row total, used only as the assertion reference.
  function automatic logic [COLS-1:0] rows_total(input logic [ROWS*COLS-1:0] v);
    logic [COLS-1:0] acc;
    acc = '0;
    for (int r = 0; r < ROWS; r++) acc = acc + v[r*COLS +: COLS];
    return acc;
  endfunction

  assign ref_total = rows_total(pp_flat);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (sum_row + carry_row) == $past(ref_total)); // R3

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum_row) && $stable(carry_row))); // R4

endmodule

// File: tb/csa_reduction_tree_test.sv
module csa_reduction_tree_test;
  localparam int ROWS = 6;
  localparam int COLS = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [ROWS*COLS-1:0] pp_flat = '0;
  logic                 out_valid;
  logic [COLS-1:0]      sum_row;
  logic [COLS-1:0]      carry_row;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  csa_reduction_tree #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .pp_flat  (pp_flat),
    .out_valid(out_valid),
    .sum_row  (sum_row),
    .carry_row(carry_row)
  );

  always #10ns clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] expect_total(input logic [ROWS*COLS-1:0] v);
    logic [COLS-1:0] t;
    t = '0;
    for (int r = ROWS - 1; r >= 0; r--) t += v[r*COLS +: COLS];
    return t;
  endfunction

  task automatic check_result(input string req, input logic [COLS-1:0] exp);
    logic [COLS-1:0] got;
    got = sum_row + carry_row;
    check(out_valid === 1'b1, {req, " out_valid"}, 32'(out_valid), 32'd1);
    check(got === exp, {req, " sum+carry"}, 32'(got), 32'(exp));
  endtask

  // Drive at a falling edge, result is read at the following falling edge.
  task automatic apply_one(input logic [ROWS*COLS-1:0] v, input string req, input logic [COLS-1:0] exp);
    @(negedge clk);
    pp_flat  = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(req, exp);
  endtask

  // Radix-4 recoded rows of signed a*b with hot-one corrections in row 4.
  function automatic logic [ROWS*COLS-1:0] booth_rows(input logic signed [7:0] a, input logic [7:0] b);
    logic [ROWS*COLS-1:0] v;
    logic [COLS-1:0] m, mag, hot;
    logic [2:0] grp;
    v   = '0;
    hot = '0;
    m   = COLS'(signed'(a));
    for (int i = 0; i < 4; i++) begin
      grp = {b[2*i+1], b[2*i], (i == 0) ? 1'b0 : b[2*i-1]};
      case (grp)
        3'b001, 3'b010: mag = m;
        3'b011:         mag = m << 1;
        3'b100:         mag = m << 1;
        3'b101, 3'b110: mag = m;
        default:        mag = '0;
      endcase
      if (grp[2] && grp != 3'b111) begin
        v[i*COLS +: COLS] = (~mag) << (2*i);
        hot[2*i] = 1'b1;
      end else begin
        v[i*COLS +: COLS] = mag << (2*i);
      end
    end
    v[4*COLS +: COLS] = hot;
    return v;
  endfunction

  // Unit-delay estimate of the tree: ordered (late bit on cin) or not.
  function automatic int tree_delay(input bit ordered);
    int hg[COLS];
    int ar[COLS][32];
    int nh[COLS];
    int na[COLS][32];
    int cy[COLS][32];
    int ncy[COLS];
    int h, x, y, z, ta, tb, tc, tmp, worst;
    for (int c = 0; c < COLS; c++) begin
      hg[c] = ROWS;
      for (int k = 0; k < 32; k++) ar[c][k] = 0;
    end
    for (int lv = 0; lv < 20; lv++) begin
      for (int c = 0; c < COLS; c++) begin
        for (int p = 0; p < hg[c]; p++)
          for (int q = 0; q + 1 < hg[c] - p; q++)
            if (ar[c][q] > ar[c][q+1]) begin
              tmp = ar[c][q]; ar[c][q] = ar[c][q+1]; ar[c][q+1] = tmp;
            end
        nh[c] = 0;
        ncy[c] = 0;
        h = hg[c];
        if (h <= 2) begin
          for (int p = 0; p < h; p++) begin na[c][nh[c]] = ar[c][p]; nh[c]++; end
        end else begin
          for (int j = 0; j < h / 3; j++) begin
            x = ar[c][3*j]; y = ar[c][3*j+1]; z = ar[c][3*j+2];
            if (ordered) begin ta = x; tb = y; tc = z; end
            else begin ta = y; tb = z; tc = x; end
            tmp = (ta > tb) ? ta : tb;
            na[c][nh[c]] = (tmp + 4 > tc + 2) ? tmp + 4 : tc + 2; nh[c]++;
            cy[c][ncy[c]] = (tmp + 4 > tc + 2) ? tmp + 4 : tc + 2; ncy[c]++;
          end
          if (h % 3 == 1) begin na[c][nh[c]] = ar[c][h-1]; nh[c]++; end
          if (h % 3 == 2) begin
            tmp = (ar[c][h-2] > ar[c][h-1]) ? ar[c][h-2] : ar[c][h-1];
            na[c][nh[c]] = tmp + 2; nh[c]++;
            cy[c][ncy[c]] = tmp + 2; ncy[c]++;
          end
        end
      end
      for (int c = 1; c < COLS; c++)
        for (int j = 0; j < ncy[c-1]; j++) begin na[c][nh[c]] = cy[c-1][j]; nh[c]++; end
      for (int c = 0; c < COLS; c++) begin
        hg[c] = nh[c];
        for (int k = 0; k < nh[c]; k++) ar[c][k] = na[c][k];
      end
    end
    worst = 0;
    for (int c = 0; c < COLS; c++)
      for (int k = 0; k < hg[c]; k++) if (ar[c][k] > worst) worst = ar[c][k];
    return worst;
  endfunction

  task automatic t_reset();
    #1ns;
    check(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    check(sum_row === '0, "R1 sum_row in reset", 32'(sum_row), 32'd0);
    check(carry_row === '0, "R1 carry_row in reset", 32'(carry_row), 32'd0);
  endtask

  task automatic t_basic_patterns();
    logic [ROWS*COLS-1:0] v;
    apply_one('0, "R3 all zero", '0);
    v = '0;
    v[2*COLS +: COLS] = 16'hA5C3;
    apply_one(v, "R3 single row", 16'hA5C3);
    v = '0;
    for (int c = 0; c < COLS; c++) v[(c % ROWS)*COLS + c] = 1'b1;
    apply_one(v, "R3 diagonal", expect_total(v));
    v = '0;
    for (int r = 0; r < ROWS; r++) v[r*COLS + COLS - 1] = 1'b1;
    apply_one(v, "R5 top column only", expect_total(v));
  endtask

  task automatic t_all_ones();
    logic [COLS-1:0] exp;
    exp = '0;
    for (int r = 0; r < ROWS; r++) exp = exp - 1'b1;
    apply_one('1, "R5 all ones wrap", exp);
  endtask

  task automatic t_booth();
    logic signed [7:0] av [8] = '{8'sd0, 8'sd1, -8'sd1, 8'sd127, -8'sd128, -8'sd128, 8'sd93, -8'sd57};
    logic signed [7:0] bv [8] = '{8'sd77, -8'sd1, -8'sd1, 8'sd127, -8'sd128, 8'sd127, -8'sd34, 8'sd85};
    logic signed [15:0] prod;
    for (int i = 0; i < 8; i++) begin
      prod = av[i] * bv[i];
      apply_one(booth_rows(av[i], bv[i]), "R7 recoded product", prod);
    end
  endtask

  task automatic t_back_to_back();
    logic [ROWS*COLS-1:0] v;
    logic [COLS-1:0] exp_prev;
    exp_prev = '0;
    for (int i = 0; i <= 40; i++) begin
      @(negedge clk);
      if (i > 0) check_result("R6 back-to-back", exp_prev);
      if (i < 40) begin
        for (int w = 0; w < ROWS*COLS/32; w++) v[w*32 +: 32] = $urandom();
        pp_flat  = v;
        in_valid = 1'b1;
        exp_prev = expect_total(v);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid === 1'b0, "R2 drop after burst", 32'(out_valid), 32'd0);
  endtask

  task automatic t_hold();
    logic [COLS-1:0] s0, c0;
    apply_one({ROWS{16'h1357}}, "R3 repeated row", expect_total({ROWS{16'h1357}}));
    s0 = sum_row;
    c0 = carry_row;
    for (int i = 0; i < 3; i++) begin
      pp_flat = {ROWS{$urandom_range(0, 65535)}};
      @(negedge clk);
      check(out_valid === 1'b0, "R2 idle out_valid", 32'(out_valid), 32'd0);
      check(sum_row === s0, "R4 sum_row held", 32'(sum_row), 32'(s0));
      check(carry_row === c0, "R4 carry_row held", 32'(carry_row), 32'(c0));
    end
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    pp_flat  = '1;
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    t_reset();
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 idle after reset", 32'(out_valid), 32'd0);
  endtask

  initial begin
    $display("Tree delay estimate: ordered=%0d units, unordered=%0d units",
             tree_delay(1'b1), tree_delay(1'b0));
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_basic_patterns();
    t_all_ones();
    t_booth();
    t_back_to_back();
    t_hold();
    t_reset_mid();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule